// File: doc/BRIEF.md
# Interleaved Bank Cell Writer

This block is the write side of a switch buffer whose storage is several slow DRAM banks. Packet data arrives a few bits per clock and is shifted into a gathering register. Once enough beats have arrived to fill one cell, which is one bank word, the cell is sent as a single write to the bank that is next in a fixed rotation. No single bank has to keep up with the line rate, because consecutive cells land in different banks.

After a bank accepts a cell it stays busy for a programmable number of clock cycles. A per-bank down-counter tracks this time. The rotation never skips a bank. If the bank whose turn it is is still busy when a cell completes, that cell is discarded, an overrun count goes up, and the rotation moves on anyway. Each accepted write carries the following, so that a later stage can find the cell again:
- the bank number,
- a per-bank slot address that increments after each write to that bank,
- a flag marking the first cell of a packet.

For this to work, the bank count must cover twice the ratio of bank write time to cell time, rounded up. With the default sizing (13 banks of 40-byte cells) the rotation period is long enough to hide the bank latency.

Top module: `ilv_bank_writer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, wr_en_o, drop_o, every bank_busy_o bit and overrun_cnt_o are all 0.
- R2: A cell completes on the clock edge that samples the CELL_W/IN_W-th beat with in_valid_i high. Cycles with in_valid_i low add nothing, whatever the data and sop inputs carry. In wr_data_o the earliest beat sits in the most significant IN_W bits and the last beat in bits IN_W-1:0.
- R3: Completed cells target banks 0, 1, ..., NUM_BANKS-1, then wrap back to 0. A dropped cell also consumes its bank's turn.
- R4: wr_en_o or drop_o is high for exactly one cycle: the cycle that follows the edge on which the cell completed. The two are never high together.
- R5: After an accepted write to bank b, bank_busy_o[b] is high for exactly BANK_LAT cycles, beginning with the cycle in which wr_en_o is high.
- R6: A cell is accepted only if its target bank shows bank_busy_o low in the cycle of its last beat. The earliest reuse of a bank is therefore a completion BANK_LAT+1 edges after its previous accepting edge. Otherwise the cell is dropped: drop_o is high and no write is issued.
- R7: overrun_cnt_o increases by one for each dropped cell. It holds at its maximum value (all ones) once reached.
- R8: wr_addr_o is the target bank's slot address. Each bank's slot address starts at 0 after reset, advances by one (modulo 2^ADDR_W) on each accepted write to that bank, and does not change on drops.
- R9: wr_sop_o equals the in_sop_i value sampled with the first beat of the cell. in_sop_i on any later beat has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Beat valid |
| in_data_i | input | IN_W | Beat data |
| in_sop_i | input | 1 | Beat opens a packet (sampled on a cell's first beat) |
| wr_en_o | output | 1 | Bank write strobe |
| wr_bank_o | output | $clog2(NUM_BANKS) | Target bank |
| wr_addr_o | output | ADDR_W | Slot address inside the bank |
| wr_data_o | output | CELL_W | Cell data |
| wr_sop_o | output | 1 | Cell starts a packet |
| drop_o | output | 1 | Cell discarded, target bank busy |
| bank_busy_o | output | NUM_BANKS | Per-bank busy flags |
| overrun_cnt_o | output | OVR_W | Saturating drop count |

## Verification
Two events can fall on the same clock edge: a bank's busy window expiring, and a new cell completing that targets that bank. The bench provokes this by streaming cells back to back into two instances. Both see the same beats and differ only in bank latency. With a three-bank rotation and four beats per cell, each bank is revisited twelve edges later. That is exactly the first legal reuse for a latency of 11, and one cycle too early for a latency of 12. A model in the bench built on edge numbers decides, for each instance, whether every cell is written or dropped. The pointer, slot address, busy window and overrun count of both instances are then compared cycle by cycle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  function automatic int rr_next(int cur, int n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/ilv_cell_gather.sv
module ilv_cell_gather #(
  parameter int IN_W   = 8,
  parameter int CELL_W = 320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_W-1:0]   data_i,
  input  logic              sop_i,
  output logic              done_o,
  output logic [CELL_W-1:0] cell_o,
  output logic              sop_o
);
  localparam int BEATS  = CELL_W / IN_W;
  localparam int CNT_W  = (BEATS > 2) ? $clog2(BEATS) : 1;
  localparam int HOLD_W = CELL_W - IN_W;

  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  beat_q;
  logic              first_sop_q;
  logic              last_beat;

  assign last_beat = (beat_q == CNT_W'(BEATS - 1));
  assign done_o    = valid_i && last_beat;
  assign cell_o    = {hold_q, data_i};
  assign sop_o     = first_sop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q      <= '0;
      first_sop_q <= 1'b0;
    end else if (valid_i) begin
      beat_q <= last_beat ? '0 : beat_q + 1'b1;
      if (beat_q == '0) first_sop_q <= sop_i;
    end
  end

  generate
    if (HOLD_W > IN_W) begin : g_shift_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hold_q <= '0;
        else if (valid_i) hold_q <= {hold_q[HOLD_W-IN_W-1:0], data_i};
      end
    end else begin : g_shift_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hold_q <= '0;
        else if (valid_i) hold_q <= data_i;
      end
    end
  endgenerate
endmodule

// File: rtl/ilv_bank_slot.sv
module ilv_bank_slot #(
  parameter int BANK_LAT = 200,
  parameter int ADDR_W   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int TMR_W = $clog2(BANK_LAT + 1);

  logic [TMR_W-1:0]  timer_q;
  logic [ADDR_W-1:0] addr_q;

  assign busy_o = (timer_q != '0);
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      addr_q  <= '0;
    end else if (load_i) begin
      timer_q <= TMR_W'(BANK_LAT);
      addr_q  <= addr_q + 1'b1;
    end else if (busy_o) begin
      timer_q <= timer_q - 1'b1;
    end
  end
endmodule

// File: rtl/ilv_bank_writer.sv
module ilv_bank_writer
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 13,
  parameter int IN_W      = 8,
  parameter int CELL_W    = 320,
  parameter int BANK_LAT  = 200,
  parameter int ADDR_W    = 10,
  parameter int OVR_W     = 16,
  localparam int IDX_W    = (NUM_BANKS > 2) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [IN_W-1:0]      in_data_i,
  input  logic                 in_sop_i,
  output logic                 wr_en_o,
  output logic [IDX_W-1:0]     wr_bank_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [CELL_W-1:0]    wr_data_o,
  output logic                 wr_sop_o,
  output logic                 drop_o,
  output logic [NUM_BANKS-1:0] bank_busy_o,
  output logic [OVR_W-1:0]     overrun_cnt_o
);
  logic              cell_done;
  logic [CELL_W-1:0] cell_data;
  logic              cell_sop;

  ilv_cell_gather #(.IN_W(IN_W), .CELL_W(CELL_W)) u_gather (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .data_i  (in_data_i),
    .sop_i   (in_sop_i),
    .done_o  (cell_done),
    .cell_o  (cell_data),
    .sop_o   (cell_sop)
  );

  logic [IDX_W-1:0]     ptr_q;
  logic [NUM_BANKS-1:0] busy;
  logic [NUM_BANKS-1:0] load;
  logic [ADDR_W-1:0]    slot_addr [NUM_BANKS];
  logic                 tgt_busy;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign load[b] = cell_done && (ptr_q == IDX_W'(b)) && !busy[b];
      ilv_bank_slot #(.BANK_LAT(BANK_LAT), .ADDR_W(ADDR_W)) u_slot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load[b]),
        .busy_o (busy[b]),
        .addr_o (slot_addr[b])
      );
    end
  endgenerate

  assign tgt_busy = busy[ptr_q];

  logic              wr_en_q, drop_q, sop_q;
  logic [IDX_W-1:0]  bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CELL_W-1:0] data_q;
  logic [OVR_W-1:0]  ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q <= 1'b0;
      drop_q  <= 1'b0;
      sop_q   <= 1'b0;
      bank_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      ovr_q   <= '0;
      ptr_q   <= '0;
    end else begin
      wr_en_q <= cell_done && !tgt_busy;
      drop_q  <= cell_done && tgt_busy;
      if (cell_done) begin
        // rotation advances whether or not the cell is kept
        ptr_q <= IDX_W'(rr_next(32'(ptr_q), NUM_BANKS));
        if (!tgt_busy) begin
          bank_q <= ptr_q;
          addr_q <= slot_addr[ptr_q];
          data_q <= cell_data;
          sop_q  <= cell_sop;
        end else if (ovr_q != '1) begin
          ovr_q <= ovr_q + 1'b1;
        end
      end
    end
  end

  assign wr_en_o       = wr_en_q;
  assign drop_o        = drop_q;
  assign wr_bank_o     = bank_q;
  assign wr_addr_o     = addr_q;
  assign wr_data_o     = data_q;
  assign wr_sop_o      = sop_q;
  assign bank_busy_o   = busy;
  assign overrun_cnt_o = ovr_q;
endmodule

// File: rtl/ilv_bank_writer_chk.sv
module ilv_bank_writer_chk #(
  parameter int NUM_BANKS = 13,
  parameter int OVR_W     = 16,
  localparam int IDX_W    = (NUM_BANKS > 2) ? $clog2(NUM_BANKS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_o,
  input logic                 drop_o,
  input logic [IDX_W-1:0]     wr_bank_o,
  input logic [NUM_BANKS-1:0] bank_busy_o,
  input logic [OVR_W-1:0]     overrun_cnt_o
);
  logic [IDX_W-1:0]     exp_ptr;
  logic [NUM_BANKS-1:0] busy_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_ptr <= '0;
      busy_d  <= '0;
    end else begin
      busy_d <= bank_busy_o;
      if (wr_en_o || drop_o)
        exp_ptr <= (exp_ptr == IDX_W'(NUM_BANKS - 1)) ? '0 : exp_ptr + 1'b1;
    end
  end

  assert_one_outcome_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && drop_o));

  assert_rotation_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_bank_o == exp_ptr));

  assert_busy_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> bank_busy_o[wr_bank_o]);

  assert_no_write_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !busy_d[wr_bank_o]);

  assert_drop_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> busy_d[exp_ptr]);

  assert_ovr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && ($past(overrun_cnt_o) != '1)) |-> (overrun_cnt_o == $past(overrun_cnt_o) + 1'b1));

  assert_ovr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drop_o |-> $stable(overrun_cnt_o));
endmodule

bind ilv_bank_writer ilv_bank_writer_chk #(.NUM_BANKS(NUM_BANKS), .OVR_W(OVR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_o       (wr_en_o),
  .drop_o        (drop_o),
  .wr_bank_o     (wr_bank_o),
  .bank_busy_o   (bank_busy_o),
  .overrun_cnt_o (overrun_cnt_o)
);

// File: tb/ilv_bank_writer_tb_top.sv
module ilv_bank_writer_tb_top;
  localparam int NB = 3, IW = 4, CW = 16, AW = 2, OW = 3;
  localparam int BEATS = CW / IW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [IW-1:0] in_data = '0;
  always #2.5 clk = ~clk;

  logic en0, drop0, sop0, en1, drop1, sop1;
  logic [1:0] bank0, bank1, addr0, addr1;
  logic [CW-1:0] data0, data1;
  logic [NB-1:0] busy0, busy1;
  logic [OW-1:0] ovr0, ovr1;

  ilv_bank_writer #(.NUM_BANKS(NB), .IN_W(IW), .CELL_W(CW), .BANK_LAT(11), .ADDR_W(AW), .OVR_W(OW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data), .in_sop_i(in_sop),
    .wr_en_o(en0), .wr_bank_o(bank0), .wr_addr_o(addr0), .wr_data_o(data0), .wr_sop_o(sop0),
    .drop_o(drop0), .bank_busy_o(busy0), .overrun_cnt_o(ovr0));

  ilv_bank_writer #(.NUM_BANKS(NB), .IN_W(IW), .CELL_W(CW), .BANK_LAT(12), .ADDR_W(AW), .OVR_W(OW)) dut_slow_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data), .in_sop_i(in_sop),
    .wr_en_o(en1), .wr_bank_o(bank1), .wr_addr_o(addr1), .wr_data_o(data1), .wr_sop_o(sop1),
    .drop_o(drop1), .bank_busy_o(busy1), .overrun_cnt_o(ovr1));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int lat [2] = '{11, 12};
  int last_edge [2][NB];
  int addr_m [2][NB];
  int ptr_m [2];
  int ovr_m [2];
  bit exp_en [2], exp_drop [2];
  int exp_bank [2], exp_addr [2];
  bit [NB-1:0] exp_busy [2];
  logic [CW-1:0] acc = '0;
  bit cell_sop = 0;
  int bc = 0, edge_n = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp(int j, logic en, logic drop, logic [1:0] bank, logic [1:0] addr,
                     logic [CW-1:0] data, logic sop, logic [NB-1:0] busy, logic [OW-1:0] ovr);
    check($sformatf("R4 wr_en dut%0d edge%0d", j, edge_n), 64'(en), 64'(exp_en[j]));
    check($sformatf("R6 drop dut%0d edge%0d", j, edge_n), 64'(drop), 64'(exp_drop[j]));
    if (exp_en[j] && en) begin
      check($sformatf("R3 bank dut%0d", j), 64'(bank), 64'(exp_bank[j]));
      check($sformatf("R8 addr dut%0d", j), 64'(addr), 64'(exp_addr[j]));
      check($sformatf("R2 data dut%0d", j), 64'(data), 64'(acc));
      check($sformatf("R9 sop dut%0d", j), 64'(sop), 64'(cell_sop));
    end
    check($sformatf("R5 busy dut%0d edge%0d", j, edge_n), 64'(busy), 64'(exp_busy[j]));
    check($sformatf("R7 overrun dut%0d", j), 64'(ovr), 64'(ovr_m[j]));
  endtask

  // called at a negedge; drives one cycle and checks the result at the next negedge
  task automatic step(input logic v, input logic [IW-1:0] d, input logic s);
    in_valid = v; in_data = d; in_sop = s;
    @(posedge clk);
    edge_n++;
    for (int j = 0; j < 2; j++) begin exp_en[j] = 0; exp_drop[j] = 0; end
    if (v) begin
      if (bc == 0) cell_sop = s;
      acc = {acc[CW-IW-1:0], d};
      bc++;
      if (bc == BEATS) begin
        bc = 0;
        for (int j = 0; j < 2; j++) begin
          int b = ptr_m[j];
          if (edge_n - last_edge[j][b] >= lat[j] + 1) begin
            exp_en[j] = 1; exp_bank[j] = b; exp_addr[j] = addr_m[j][b];
            addr_m[j][b] = (addr_m[j][b] + 1) % 4;
            last_edge[j][b] = edge_n;
          end else begin
            exp_drop[j] = 1;
            if (ovr_m[j] < 7) ovr_m[j]++;
          end
          ptr_m[j] = (b + 1) % NB;
        end
      end
    end
    for (int j = 0; j < 2; j++)
      for (int b = 0; b < NB; b++)
        exp_busy[j][b] = (edge_n - last_edge[j][b]) < lat[j];
    @(negedge clk);
    cmp(0, en0, drop0, bank0, addr0, data0, sop0, busy0, ovr0);
    cmp(1, en1, drop1, bank1, addr1, data1, sop1, busy1, ovr1);
  endtask

  initial begin
    for (int j = 0; j < 2; j++) begin
      ptr_m[j] = 0; ovr_m[j] = 0;
      for (int b = 0; b < NB; b++) begin last_edge[j][b] = -100; addr_m[j][b] = 0; end
    end
    repeat (3) @(negedge clk);
    // R1 reset state, both instances
    check("R1 reset outputs dut0", {en0, drop0, busy0, ovr0}, '0);
    check("R1 reset outputs dut1", {en1, drop1, busy1, ovr1}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    edge_n++;
    check("R1 after release dut0", {en0, drop0, busy0, ovr0}, '0);
    check("R1 after release dut1", {en1, drop1, busy1, ovr1}, '0);

    // back-to-back cells: boundary reuse for dut_i, drops and saturation for dut_slow_i
    for (int c = 0; c < 24; c++)
      for (int k = 0; k < BEATS; k++)
        step(1'b1, IW'(c * 7 + k * 3 + 1), (k == 0) && (c % 4 == 0));

    // idle cycles inside cells, sop on a later beat (ignored), sop while idle (ignored)
    for (int c = 0; c < 6; c++)
      for (int k = 0; k < BEATS; k++) begin
        if (k == 2) step(1'b0, 4'hF, 1'b1);
        step(1'b1, IW'(c * 5 + k + 9), (k == 1) || (k == 0 && c == 3));
      end

    // growing gaps between cells
    for (int c = 0; c < 10; c++) begin
      for (int k = 0; k < BEATS; k++) step(1'b1, IW'(15 - c - k), (k == 0) && c[0]);
      for (int g = 0; g < c; g++) step(1'b0, IW'(g), 1'b0);
    end

    // long idle: all banks drain
    for (int g = 0; g < 16; g++) step(1'b0, '0, 1'b0);
    check("R5 drained dut0", 64'(busy0), 64'(0));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule